// File: doc/BRIEF.md
# Command-Block Driven Single-Channel DMA Engine

This engine moves a block of 32-bit words from one memory region to another without help from the processor. The host writes one value, the memory address of a three-word command block, into the engine. The engine then takes the shared memory bus, reads the block, and keeps the source pointer, destination pointer and byte count it finds there. After that it waits for a peripheral to pace the transfer.

Each word moves only when the peripheral raises its request line. The engine then asks for the bus and waits for the grant. It reads the current source word, and in the next cycle writes that word to the current destination while raising the acknowledge line. It keeps the bus and the acknowledge until the peripheral drops its request, then gives up both. The bus is held for one word at a time, so the processor is locked out of memory only for short stretches. When the count reaches zero, a done flag is set and the interrupt output goes high. It stays high until the host clears it through the status register.

Top module: `desc_dma`

## Requirements
- R1: After a synchronous active-high reset, busReq, memEn, dack and irq are low, and the status register (hostSel=1) reads 0.
- R2: A write with hostSel=0 while idle stores the command-block address and starts the engine. Its first three memory reads are at that address, address+4 and address+8.
- R3: The three command-block words are taken, in address order, as source address, destination address and byte count. The byte count is a multiple of 4.
- R4: The engine starts no word transfer while dreq is low. For each word it raises busReq and holds it until busGnt is seen. It drives memEn only while busGnt is high.
- R5: Once granted, the engine reads the source word. In the next cycle it writes the data returned by that read to the destination and raises dack in that same write cycle. No other address is written.
- R6: dack stays high until dreq is low. dack and busReq fall in the same cycle, so the bus is released after every word.
- R7: After each word, the source and destination addresses each advance by 4 and the remaining count drops by 4. Exactly count/4 words are moved.
- R8: When the remaining count reaches zero, the done flag and irq go high. A zero count completes after the command-block fetch, with no dack.
- R9: The status register reads bit 0 = busy and bit 1 = done. Writing a value with bit 1 set clears done and irq. Writing with bit 1 clear leaves them unchanged.
- R10: A command-address write while busy is ignored. The command register keeps its value and no second fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostSel | input | 1 | Register select: 0 command address, 1 status |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Selected register contents |
| busReq | output | 1 | Memory bus request |
| busGnt | input | 1 | Memory bus grant |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable (0 read) |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Memory read data, valid the cycle after a read |
| dreq | input | 1 | Peripheral word-ready request |
| dack | output | 1 | Acknowledge to peripheral |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
A wrong sequencer state shows on the memory port within a cycle. Examples are a read address that is not base, base+4, base+8 and then the running source address, a write without dack, or a memory strobe without grant. A pointer or count register that is off shows as a word written to the wrong destination or a wrong number of acknowledges before irq. Both are caught at the access itself or by the end-of-transfer memory compare. A done flag that sets or clears at the wrong time shows at irq and in the status readback right after the last handshake or the clearing write.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  typedef enum logic [2:0] {
    SEL_CMD0,
    SEL_CMD1,
    SEL_CMD2,
    SEL_SRC,
    SEL_DST
  } addr_sel_e;

  typedef struct packed {
    logic      loadCmd;
    logic      capSrc;
    logic      capDst;
    logic      capCnt;
    logic      step;
    logic      setDone;
    addr_sel_e addrSel;
  } ctl_strobe_t;

endpackage

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        busGnt,
  input  logic        dreq,
  input  logic        cntZero,
  output ctl_strobe_t strobe,
  output logic        busReq,
  output logic        memEn,
  output logic        memWe,
  output logic        dack,
  output logic        busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_F0, S_F1, S_F2, S_FEND,
    S_WAIT, S_WREQ, S_WRD, S_WWR, S_WACK, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '{default: '0, addrSel: SEL_CMD0};
    busReq    = 1'b0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    dack      = 1'b0;
    unique case (state)
      S_IDLE: if (startReq) begin
        strobe.loadCmd = 1'b1;
        nextState      = S_FREQ;
      end
      S_FREQ: begin
        busReq = 1'b1;
        if (busGnt) nextState = S_F0;
      end
      S_F0: begin
        busReq = 1'b1; memEn = 1'b1;
        strobe.addrSel = SEL_CMD0;
        nextState = S_F1;
      end
      S_F1: begin
        busReq = 1'b1; memEn = 1'b1;
        strobe.addrSel = SEL_CMD1;
        strobe.capSrc  = 1'b1;
        nextState = S_F2;
      end
      S_F2: begin
        busReq = 1'b1; memEn = 1'b1;
        strobe.addrSel = SEL_CMD2;
        strobe.capDst  = 1'b1;
        nextState = S_FEND;
      end
      S_FEND: begin
        strobe.capCnt = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: begin
        if (cntZero)   nextState = S_DONE;
        else if (dreq) nextState = S_WREQ;
      end
      S_WREQ: begin
        busReq = 1'b1;
        if (busGnt) nextState = S_WRD;
      end
      S_WRD: begin
        busReq = 1'b1; memEn = 1'b1;
        strobe.addrSel = SEL_SRC;
        nextState = S_WWR;
      end
      S_WWR: begin
        busReq = 1'b1; memEn = 1'b1; memWe = 1'b1; dack = 1'b1;
        strobe.addrSel = SEL_DST;
        strobe.step    = 1'b1;
        nextState = S_WACK;
      end
      S_WACK: begin
        busReq = 1'b1; dack = 1'b1;
        if (!dreq) nextState = S_WAIT;
      end
      S_DONE: begin
        strobe.setDone = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  AST_MEM_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    memEn |-> busGnt);                                         // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGnt) |=> busReq);                           // R4
  AST_DACK_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(dack) |-> (memEn && memWe));                         // R5
  AST_DACK_WAITS_DREQ: assert property (@(posedge clk) disable iff (rst)
    (dack && dreq) |=> dack);                                  // R6
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(dack) |-> !busReq);                                  // R6

endmodule

// File: rtl/desc_dma_path.sv
module desc_dma_path
  import desc_dma_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_strobe_t       strobe,
  input  logic              clrDone,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic [WORD_W-1:0] cmdAddr,
  output logic              cntZero,
  output logic              doneFlag
);

  localparam int STEP = WORD_W / 8;
  localparam logic [WORD_W-1:0] STEP_V  = WORD_W'(STEP);
  localparam logic [WORD_W-1:0] STEP2_V = WORD_W'(2 * STEP);

  logic [WORD_W-1:0] srcReg, dstReg, cntReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdAddr <= '0;
      srcReg  <= '0;
      dstReg  <= '0;
      cntReg  <= '0;
    end else begin
      if (strobe.loadCmd) cmdAddr <= hostWrData;
      if (strobe.capSrc)  srcReg  <= memRdData;
      if (strobe.capDst)  dstReg  <= memRdData;
      if (strobe.capCnt)  cntReg  <= memRdData;
      if (strobe.step) begin
        srcReg <= srcReg + STEP_V;
        dstReg <= dstReg + STEP_V;
        cntReg <= cntReg - STEP_V;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 doneFlag <= 1'b0;
    else if (strobe.setDone) doneFlag <= 1'b1;
    else if (clrDone)        doneFlag <= 1'b0;
  end

  always_comb begin
    unique case (strobe.addrSel)
      SEL_CMD1: memAddr = cmdAddr + STEP_V;
      SEL_CMD2: memAddr = cmdAddr + STEP2_V;
      SEL_SRC:  memAddr = srcReg;
      SEL_DST:  memAddr = dstReg;
      default:  memAddr = cmdAddr;
    endcase
  end

  assign memWrData = memRdData;
  assign cntZero   = (cntReg == '0);

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clrDone && !strobe.setDone) |=> !doneFlag);               // R9
  AST_STEP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> !cntZero);                                 // R7

endmodule

// File: rtl/desc_dma.sv
module desc_dma
  import desc_dma_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWrEn,
  input  logic              hostSel,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              dreq,
  output logic              dack,
  output logic              irq
);

  ctl_strobe_t       strobe;
  logic              busy, cntZero, doneFlag, startReq, clrDone;
  logic [WORD_W-1:0] cmdAddr;

  assign startReq = hostWrEn && !hostSel;
  assign clrDone  = hostWrEn && hostSel && hostWrData[1];

  desc_dma_ctrl i_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .busGnt(busGnt),
    .dreq(dreq), .cntZero(cntZero), .strobe(strobe), .busReq(busReq),
    .memEn(memEn), .memWe(memWe), .dack(dack), .busy(busy)
  );

  desc_dma_path #(.WORD_W(WORD_W)) i_path (
    .clk(clk), .rst(rst), .strobe(strobe), .clrDone(clrDone),
    .hostWrData(hostWrData), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .cmdAddr(cmdAddr), .cntZero(cntZero),
    .doneFlag(doneFlag)
  );

  assign irq        = doneFlag;
  assign hostRdData = hostSel ? {{(WORD_W-2){1'b0}}, doneFlag, busy} : cmdAddr;

  AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && startReq) |=> $stable(cmdAddr));                  // R10

endmodule

// File: tb/test_desc_dma.sv
module test_desc_dma;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWrEn = 1'b0, hostSel = 1'b0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic        busReq, busGnt, memEn, memWe, dack, irq;
  logic [31:0] memAddr, memWrData, memRdData;
  logic        dreq = 1'b0;

  int checks = 0, fails = 0;
  int gntDelay = 0;
  logic [1:0] waitCnt;
  logic [31:0] mem [0:63];

  logic [31:0] expBase, expSrc, expDst;
  int readIdx, writeIdx, dackRises;
  bit monOn = 0;
  logic prevDack = 1'b0;

  always #5 clk = ~clk;

  desc_dma i_desc_dma (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busReq(busReq),
    .busGnt(busGnt), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .dreq(dreq),
    .dack(dack), .irq(irq)
  );

  always @(posedge clk) begin
    if (!busReq) waitCnt <= '0;
    else if (32'(waitCnt) < gntDelay) waitCnt <= waitCnt + 2'd1;
    if (memEn && memWe) mem[memAddr[7:2]] <= memWrData;
    memRdData <= mem[memAddr[7:2]];
  end
  assign busGnt = busReq && (32'(waitCnt) >= gntDelay);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && monOn) begin
      if (memEn && !memWe) begin
        if (readIdx < 3) check(memAddr == expBase + 32'(4*readIdx), "R2 fetch addr",
                               memAddr, expBase + 32'(4*readIdx));
        else check(memAddr == expSrc + 32'(4*(readIdx-3)), "R7 src addr",
                   memAddr, expSrc + 32'(4*(readIdx-3)));
        readIdx++;
      end
      if (memEn && memWe) begin
        check(dack, "R5 dack with write", 32'(dack), 1);
        check(memAddr == expDst + 32'(4*writeIdx), "R7 dst addr",
              memAddr, expDst + 32'(4*writeIdx));
        check(memWrData == mem[16+writeIdx], "R5 write data",
              memWrData, mem[16+writeIdx]);
        writeIdx++;
      end
      if (dack && !prevDack) begin
        dackRises++;
        check(dreq, "R4 dack only after dreq", 32'(dreq), 1);
      end
      if (!dack && prevDack)
        check(!busReq && !dreq, "R6 release", {30'b0, busReq, dreq}, 0);
      prevDack = dack;
    end
  end

  task automatic hostWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = sel; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] v);
    hostSel = sel;
    #1;
    v = hostRdData;
  endtask

  task automatic oneWord();
    @(negedge clk);
    dreq = 1'b1;
    while (!dack) @(negedge clk);
    @(negedge clk);
    dreq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic runOne(input int nWords, input int dly);
    logic [31:0] v;
    gntDelay = dly;
    for (int i = 0; i < 8; i++) begin
      mem[16+i] = 32'hA000_0000 + 32'(dly*256 + i*17 + 1);
      mem[32+i] = 32'hDEAD_0000 + 32'(i);
    end
    mem[4] = 32'h40; mem[5] = 32'h80; mem[6] = 32'(nWords*4);
    expBase = 32'h10; expSrc = 32'h40; expDst = 32'h80;
    readIdx = 0; writeIdx = 0; dackRises = 0; monOn = 1;
    hostWrite(1'b0, 32'h10);
    readReg(1'b1, v);
    check(v[0] == 1'b1, "R9 busy bit", v, 1);
    hostWrite(1'b0, 32'h20);
    readReg(1'b0, v);
    check(v == 32'h10, "R10 cmd ignored while busy", v, 32'h10);
    repeat (12) @(negedge clk);
    check(readIdx == 3, "R2 R3 three fetch reads", 32'(readIdx), 3);
    if (nWords > 0)
      check(!busReq && dackRises == 0 && !irq, "R4 idle without dreq",
            {29'b0, busReq, irq, 1'b0} | 32'(dackRises), 0);
    for (int w = 0; w < nWords; w++) oneWord();
    for (int t = 0; t < 20 && !irq; t++) @(negedge clk);
    check(irq, "R8 irq at completion", 32'(irq), 1);
    check(dackRises == nWords, "R8 handshake count", 32'(dackRises), 32'(nWords));
    check(writeIdx == nWords, "R7 write count", 32'(writeIdx), 32'(nWords));
    check(readIdx == 3 + nWords, "R10 R7 read count", 32'(readIdx), 32'(3+nWords));
    for (int i = 0; i < 8; i++) begin
      v = (i < nWords) ? 32'hA000_0000 + 32'(dly*256 + i*17 + 1)
                       : 32'hDEAD_0000 + 32'(i);
      check(mem[32+i] == v, "R5 R3 dst contents", mem[32+i], v);
    end
    readReg(1'b1, v);
    check(v == 32'h2, "R9 status done", v, 2);
    hostWrite(1'b1, 32'h1);
    check(irq, "R9 write without bit1", 32'(irq), 1);
    hostWrite(1'b1, 32'h2);
    readReg(1'b1, v);
    check(!irq && v == 0, "R9 clear done", {31'b0, irq} | v, 0);
    monOn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    readReg(1'b1, v);
    check(!busReq && !memEn && !dack && !irq && v == 0, "R1 reset state",
          {28'b0, busReq, memEn, dack, irq} | v, 0);
    for (int d = 0; d < 3; d++)
      for (int n = 0; n <= 4; n++) runOne(n, d);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule